// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block runs one four-beat burst read with auto-precharge against a synchronous DRAM, for a bus controller that serves two chip-select areas. A single-cycle request carrying a row address, a column address and an area select starts an access. The block drives the command lines (chip select, RAS, CAS, write enable), the byte masks and the address bus. It raises a bus-start strobe in the first cycle, collects four data words from the memory and hands each one back with a one-cycle valid pulse.

Two timings are programmable and are sampled when a request is accepted. A 2-bit activate-to-read field inserts 0 to 3 NOP cycles between the activate and the read command. Each area has its own 2-bit read latency field, so the latency from the read command to the first captured word runs from 1 to 4 cycles. The field in use is picked by the area of the request.

States and transitions: IDLE (deselected) goes to ACT on a request. ACT issues the activate and goes to RCDW when NOPs are due, otherwise to READ. RCDW issues NOPs until the delay has run out and then goes to READ. READ issues read-with-precharge and goes to CLW when the latency is above 1, otherwise to BEAT. CLW issues NOPs until data is due. BEAT captures four words. DEND is a data-end NOP cycle. PRE is the precharge NOP cycle, and it returns to IDLE.

Top module: `sdram_burst_rd`

## Requirements
- R1: Out of reset and whenever idle, sd_cs_n is 1, sd_dqm is all ones, busy is 0 and rd_valid is 0.
- R2: A request seen in idle makes the next cycle the activate cycle: command {cs_n,ras_n,cas_n,we_n} = 0011, sd_addr equals the request row, and bus_start is 1 for that one cycle only.
- R3: With activate-to-read field value t (0..3), exactly t NOP cycles (command 0111) follow the activate, and the read command (0101) comes t+1 cycles after it.
- R4: During the read command, sd_addr bits [COL_W-1:0] carry the column, bit AP_BIT (10) is 1 to request auto-precharge, and all other bits are 0.
- R5: The read latency is (field+1) cycles, from cl_sel_a0 when req_area is 0 and from cl_sel_a1 when req_area is 1.
- R6: With read latency c and the read command in cycle r, sd_dq_in is captured in cycles r+c to r+c+3 in that order, and each word appears on rd_data with rd_valid high in the following cycle.
- R7: After the fourth capture cycle come one data-end NOP cycle and one precharge NOP cycle, and then idle. busy is high for exactly t+c+7 cycles, starting with the activate cycle.
- R8: Requests and changes to the request or timing inputs while busy have no effect on the running access and start no second one.
- R9: While busy, sd_cs_n is 0 and sd_dqm is all zeros, and every cycle other than the activate and read cycles carries NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start an access (taken only when idle) |
| req_area | input | 1 | Chip-select area of the access |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| trcd_sel | input | 2 | Activate-to-read field, NOP count |
| cl_sel_a0 | input | 2 | Read latency field, area 0 |
| cl_sel_a1 | input | 2 | Read latency field, area 1 |
| sd_dq_in | input | DATA_W | Data from memory |
| busy | output | 1 | Access in progress |
| bus_start | output | 1 | First-cycle strobe |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | DATA_W/8 | Byte masks |
| sd_addr | output | ROW_W | Memory address bus |
| rd_data | output | DATA_W | Captured word |
| rd_valid | output | 1 | rd_data valid pulse |

## Verification
The bench uses the default parameters: a 13-bit address bus, 9-bit columns, the precharge bit at 10 and 32-bit data. Because both timing fields are only two bits wide, it can sweep every activate-to-read value against every latency value in both areas, with the other area's field always set to a different value. For each access it works out the command sequence, the busy length and the cycle and value of every returned word from t and c. The memory data changes every cycle, so a word captured one cycle early or late shows up as a wrong value.

// File: rtl/sdrb_pkg.sv
package sdrb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_RCDW,
        ST_READ,
        ST_CLW,
        ST_BEAT,
        ST_DEND,
        ST_PRE
    } sdrb_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdrb_cmd_t;

    localparam sdrb_cmd_t CMD_ACT  = 4'b0011;
    localparam sdrb_cmd_t CMD_READ = 4'b0101;
    localparam sdrb_cmd_t CMD_NOP  = 4'b0111;
    localparam sdrb_cmd_t CMD_DESL = 4'b1111;

    localparam int BURST_LEN = 4;

endpackage

// File: rtl/sdrb_cl_pick.sv
module sdrb_cl_pick #(
    parameter int AREAS   = 2,
    parameter int FIELD_W = 2,
    localparam int AW     = (AREAS > 1) ? $clog2(AREAS) : 1,
    localparam int LAT_W  = FIELD_W + 1
) (
    input  logic [AREAS*FIELD_W-1:0] cl_fields,
    input  logic [AW-1:0]            area,
    output logic [LAT_W-1:0]         cl_cycles
);

    logic [LAT_W-1:0] lat [AREAS];

    for (genvar a = 0; a < AREAS; a++) begin : g_area
        assign lat[a] = {1'b0, cl_fields[a*FIELD_W +: FIELD_W]} + LAT_W'(1);
    end

    always_comb begin
        cl_cycles = lat[0];
        for (int a = 1; a < AREAS; a++) begin
            if (area == AW'(a)) cl_cycles = lat[a];
        end
    end

endmodule

// File: rtl/sdrb_wait_cnt.sv
module sdrb_wait_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sdrb_beat_cap.sv
module sdrb_beat_cap #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= cap_en;
            if (cap_en) rd_data <= din;
        end
    end

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
    import sdrb_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 32,
    parameter int AP_BIT = 10,
    localparam int MASK_W = DATA_W / 8,
    localparam int CNT_W  = 2,
    localparam int LAT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_area,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [1:0]        trcd_sel,
    input  logic [1:0]        cl_sel_a0,
    input  logic [1:0]        cl_sel_a1,
    input  logic [DATA_W-1:0] sd_dq_in,
    output logic              busy,
    output logic              bus_start,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [MASK_W-1:0] sd_dqm,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    sdrb_state_e state, state_nxt;

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [1:0]       trcd_q;
    logic [LAT_W-1:0] cl_q;
    logic [LAT_W-1:0] cl_req;

    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_dec;
    logic             cnt_zero;
    logic             cap_en;
    sdrb_cmd_t        cmd;

    wire accept = (state == ST_IDLE) && req;

    sdrb_cl_pick #(.AREAS(2), .FIELD_W(2)) u_cl_pick (
        .cl_fields (({cl_sel_a1, cl_sel_a0})),
        .area      (req_area),
        .cl_cycles (cl_req)
    );

    sdrb_wait_cnt #(.W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    sdrb_beat_cap #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .din      (sd_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // request capture: address and timing frozen at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            trcd_q <= '0;
            cl_q   <= LAT_W'(1);
        end else if (accept) begin
            row_q  <= req_row;
            col_q  <= req_col;
            trcd_q <= trcd_sel;
            cl_q   <= cl_req;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state and wait counter control
    always_comb begin
        state_nxt = state;
        cnt_load  = 1'b0;
        cnt_val   = '0;
        cnt_dec   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) state_nxt = ST_ACT;
            end
            ST_ACT: begin
                if (trcd_q == 2'd0) begin
                    state_nxt = ST_READ;
                end else begin
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(trcd_q - 2'd1);
                    state_nxt = ST_RCDW;
                end
            end
            ST_RCDW: begin
                if (cnt_zero) state_nxt = ST_READ;
                else          cnt_dec   = 1'b1;
            end
            ST_READ: begin
                cnt_load = 1'b1;
                if (cl_q == LAT_W'(1)) begin
                    cnt_val   = CNT_W'(BURST_LEN - 1);
                    state_nxt = ST_BEAT;
                end else begin
                    cnt_val   = CNT_W'(cl_q - LAT_W'(2));
                    state_nxt = ST_CLW;
                end
            end
            ST_CLW: begin
                if (cnt_zero) begin
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(BURST_LEN - 1);
                    state_nxt = ST_BEAT;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_BEAT: begin
                if (cnt_zero) state_nxt = ST_DEND;
                else          cnt_dec   = 1'b1;
            end
            ST_DEND: state_nxt = ST_PRE;
            ST_PRE:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        bus_start = 1'b0;
        cap_en    = 1'b0;
        busy      = 1'b1;
        sd_dqm    = '0;
        unique case (state)
            ST_IDLE: begin
                cmd    = CMD_DESL;
                busy   = 1'b0;
                sd_dqm = '1;
            end
            ST_ACT: begin
                cmd       = CMD_ACT;
                sd_addr   = row_q;
                bus_start = 1'b1;
            end
            ST_READ: begin
                cmd                   = CMD_READ;
                sd_addr[COL_W-1:0]    = col_q;
                sd_addr[AP_BIT]       = 1'b1;
            end
            ST_BEAT: cap_en = 1'b1;
            ST_RCDW, ST_CLW, ST_DEND, ST_PRE: cmd = CMD_NOP;
        endcase
    end

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

endmodule

// File: rtl/sdrb_checker.sv
module sdrb_checker #(
    parameter int ROW_W  = 13,
    parameter int MASK_W = 4,
    parameter int AP_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              bus_start,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [MASK_W-1:0] sd_dqm,
    input logic [ROW_W-1:0]  sd_addr,
    input logic              rd_valid
);

    wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    // R1
    a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sd_cs_n && sd_dqm == '1 && !rd_valid));

    // R2
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start);

    // R2
    a_r2_start_is_activate: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |-> (cmd == 4'b0011 && busy));

    // R2
    a_r2_activate_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> bus_start);

    // R4
    a_r4_precharge_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0101) |-> sd_addr[AP_BIT]);

    // R9
    a_r9_masks_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sd_dqm == '0 && !sd_cs_n));

    // R8
    a_r8_no_back_to_back_act: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0011) |=> (cmd != 4'b0011 && busy));

    // R6
    a_r6_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

endmodule

bind sdram_burst_rd sdrb_checker #(
    .ROW_W  (ROW_W),
    .MASK_W (MASK_W),
    .AP_BIT (AP_BIT)
) u_sdrb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .bus_start (bus_start),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_dqm    (sd_dqm),
    .sd_addr   (sd_addr),
    .rd_valid  (rd_valid)
);

// File: tb/sdram_burst_rd_test.sv
module sdram_burst_rd_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_area = 1'b0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic [1:0]  trcd_sel = '0;
    logic [1:0]  cl_sel_a0 = '0;
    logic [1:0]  cl_sel_a1 = '0;
    logic [31:0] sd_dq_in = '0;
    logic        busy, bus_start, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, rd_valid;
    logic [3:0]  sd_dqm;
    logic [12:0] sd_addr;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sdram_burst_rd uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_area(req_area),
        .req_row(req_row), .req_col(req_col), .trcd_sel(trcd_sel),
        .cl_sel_a0(cl_sel_a0), .cl_sel_a1(cl_sel_a1), .sd_dq_in(sd_dq_in),
        .busy(busy), .bus_start(bus_start), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_dqm(sd_dqm), .sd_addr(sd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // memory data bus: a fresh word every cycle
    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        sd_dq_in = 32'hC0DE_0000 + 32'(cyc * 7);
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input int area, input int t, input int f0, input int f1,
                           input logic [12:0] row, input logic [8:0] col, input bit noise);
        int c = (area != 0 ? f1 : f0) + 1;
        int len = t + c + 7;
        logic [31:0] prev_dq = '0;
        logic [12:0] rd_addr = 13'(col) | 13'h0400;
        @(negedge clk);
        req_area = area[0]; req_row = row; req_col = col;
        trcd_sel = t[1:0]; cl_sel_a0 = f0[1:0]; cl_sel_a1 = f1[1:0];
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k <= len + 1; k++) begin
            logic [3:0] cmd;
            logic [3:0] ecmd;
            bit evalid;
            if (k > 0) @(negedge clk);
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (k >= len)        ecmd = 4'b1111;
            else if (k == 0)     ecmd = 4'b0011;
            else if (k == t + 1) ecmd = 4'b0101;
            else                 ecmd = 4'b0111;
            if (k == 0) begin
                chk(cmd == ecmd, "R2 activate cmd", 32'(cmd), 32'(ecmd));
                chk(sd_addr == row, "R2 row address", 32'(sd_addr), 32'(row));
            end else if (k <= t) begin
                chk(cmd == ecmd, "R3 rcd nop", 32'(cmd), 32'(ecmd));
            end else if (k == t + 1) begin
                chk(cmd == ecmd, "R3 read cmd timing", 32'(cmd), 32'(ecmd));
                chk(sd_addr == rd_addr, "R4 read address", 32'(sd_addr), 32'(rd_addr));
            end else if (k < len) begin
                chk(cmd == ecmd, "R9 nop in access", 32'(cmd), 32'(ecmd));
            end else begin
                chk(cmd == ecmd, "R1 idle deselect", 32'(cmd), 32'(ecmd));
                chk(sd_dqm == 4'hF, "R1 idle masks", 32'(sd_dqm), 32'hF);
            end
            if (noise) chk(cmd == ecmd, "R8 sequence unchanged", 32'(cmd), 32'(ecmd));
            chk(busy == (k < len), "R7 busy length", 32'(busy), 32'(k < len));
            chk(bus_start == (k == 0), "R2 bus start", 32'(bus_start), 32'(k == 0));
            if (k < len) chk(sd_dqm == 4'h0, "R9 masks low", 32'(sd_dqm), 32'h0);
            evalid = (k >= t + c + 2) && (k <= t + c + 5);
            chk(rd_valid == evalid, "R6 valid timing", 32'(rd_valid), 32'(evalid));
            if (evalid && rd_valid)
                chk(rd_data == prev_dq, "R5 latency data", rd_data, prev_dq);
            prev_dq = sd_dq_in;
            if (noise && k == 2) begin
                req = 1'b1; req_row = ~row; req_col = ~col; req_area = ~area[0];
                trcd_sel = ~t[1:0]; cl_sel_a0 = ~f0[1:0]; cl_sel_a1 = ~f1[1:0];
            end
            if (noise && k == len - 1) req = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sd_cs_n == 1'b1, "R1 reset cs", 32'(sd_cs_n), 32'h1);
        chk(sd_dqm == 4'hF, "R1 reset masks", 32'(sd_dqm), 32'hF);
        chk(busy == 1'b0, "R1 reset busy", 32'(busy), 32'h0);
        chk(rd_valid == 1'b0, "R1 reset valid", 32'(rd_valid), 32'h0);
        for (int a = 0; a < 2; a++)
            for (int t = 0; t < 4; t++)
                for (int f = 0; f < 4; f++) begin
                    logic [12:0] row = 13'(13'h0A5 + a * 977 + t * 131 + f * 29);
                    logic [8:0]  col = 9'(9'h13 + t * 37 + f * 11 + a * 5);
                    if (a == 0) run_txn(a, t, f, 3 - f, row, col, 1'b0);
                    else        run_txn(a, t, 3 - f, f, row, col, 1'b0);
                end
        run_txn(0, 1, 2, 0, 13'h1ABC, 9'h0F0, 1'b1);
        run_txn(1, 3, 1, 3, 13'h0155, 9'h1FF, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule